// File: doc/BRIEF.md
# Zone Access Protection Checker

This block sits beside a data-side translation path and decides, for every data access or cache-control operation, whether the operation may go ahead, must raise a data storage interrupt, or is to be quietly dropped as a no-op. It keeps a 32-bit zone word divided into sixteen 2-bit zone fields. Software loads the whole word through a one-cycle write port. The zone fields give coarse permission overrides on top of the write bit of the translation entry.

For each request the caller supplies the zone index and write bit of an entry that has already matched. It also supplies the operation class, the privilege level and the data-translation-enable flag. One cycle later the block returns a response strobe with a 2-bit verdict. Loads and stores follow the zone rules directly. Cache-control operations follow a per-operation rule: some fault only on a zone denial, some only on a write denial, some on both, and the speculative ones turn into no-ops instead of faulting.

Top module: `zone_guard`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_verdict` is 00 and every zone field is 00.
- R2: When `zpr_we` is high the whole word `zpr_wdata` is stored at that clock edge. Zone n occupies bits [31-2n:30-2n], so zone 0 is bits 31:30 and zone 15 is bits 1:0. A request made in the same cycle as a write is judged with the old word.
- R3: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Verdict codes are 00 proceed, 01 fault and 10 no-op.
- R4: When `req_xlat` is 0, every operation gets proceed.
- R5: A load (op 0) faults only when the level is user (`req_sup`=0) and the zone value is 00. The entry write bit never affects a load, and a supervisor load never faults.
- R6: Write permission is granted when any of these holds: the entry write bit is 1, the zone value is 11, or the zone value is 10 at supervisor level. A store (op 1) faults on a user zone-00 denial or when write permission is not granted.
- R7: Data-cache flush (op 3), data-cache store-back (op 5) and instruction-cache block invalidate (op 11) fault only on a user zone-00 denial.
- R8: Data-cache invalidate (op 4) and data-cache congruence invalidate (op 9) fault only when write permission is not granted. A zone value of 00 alone never makes them fault.
- R9: Data-cache zero (op 8) faults on a user zone-00 denial or when write permission is not granted.
- R10: Data-cache allocate (op 2) never faults. Where a user zone-00 denial or a missing write permission applies, its verdict is no-op.
- R11: Data-cache touch (op 6) and touch-for-store (op 7) give no-op on a user zone-00 denial, and otherwise proceed even without write permission.
- R12: Data-cache read (op 10), instruction-cache touch (op 12), instruction-cache congruence invalidate (op 13), instruction-cache read (op 14) and the unused code 15 always proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zpr_we | input | 1 | Zone word write strobe |
| zpr_wdata | input | 32 | New zone word |
| req_valid | input | 1 | Request strobe |
| req_zone | input | 4 | Zone index from the matched entry |
| req_wr | input | 1 | Write bit from the matched entry |
| req_op | input | 4 | Operation class code |
| req_sup | input | 1 | 1 = supervisor, 0 = user |
| req_xlat | input | 1 | Data translation enabled |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_verdict | output | 2 | 00 proceed, 01 fault, 10 no-op |

## Verification
A zone word written at a clock edge affects requests from the next edge on. A verdict appears on the ports one edge after its request is captured. The bench drives each request at a falling edge, lets exactly one rising edge pass, and samples `rsp_valid` and `rsp_verdict` at the next falling edge. It then drops `req_valid`, so each response is tied to the one request before it. The same-cycle case drives a write and a request on the same falling edge and expects the verdict from the old word. A request sent afterwards must then reflect the new word.

// File: rtl/zg_pkg.sv
package zg_pkg;

  localparam int ZONE_W = 2;
  localparam int OP_W   = 4;

  typedef enum logic [1:0] {
    VERD_GO    = 2'b00,
    VERD_FAULT = 2'b01,
    VERD_NOP   = 2'b10
  } verdict_e;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD      = 4'd0,
    OP_STORE     = 4'd1,
    OP_DC_ALLOC  = 4'd2,
    OP_DC_FLUSH  = 4'd3,
    OP_DC_INVAL  = 4'd4,
    OP_DC_STBACK = 4'd5,
    OP_DC_TOUCH  = 4'd6,
    OP_DC_TOUCHW = 4'd7,
    OP_DC_ZERO   = 4'd8,
    OP_DC_CCINV  = 4'd9,
    OP_DC_READ   = 4'd10,
    OP_IC_INVAL  = 4'd11,
    OP_IC_TOUCH  = 4'd12,
    OP_IC_CCINV  = 4'd13,
    OP_IC_READ   = 4'd14,
    OP_RSVD      = 4'd15
  } op_e;

  // User level with zone 00 loses all access.
  function automatic logic zone_denies(input logic [ZONE_W-1:0] z, input logic sup);
    return !sup && (z == 2'b00);
  endfunction

  // Write granted by entry bit, by zone 11, or by zone 10 at supervisor level.
  function automatic logic write_denies(input logic [ZONE_W-1:0] z, input logic sup,
                                        input logic wr);
    logic granted;
    granted = wr || (z == 2'b11) || (sup && (z == 2'b10));
    return !granted;
  endfunction

  function automatic verdict_e judge(input op_e op, input logic [ZONE_W-1:0] z,
                                     input logic sup, input logic wr, input logic xlat);
    logic zd;
    logic wd;
    verdict_e v;
    zd = zone_denies(z, sup);
    wd = write_denies(z, sup, wr);
    v  = VERD_GO;
    if (xlat) begin
      case (op)
        OP_LOAD:                              v = zd ? VERD_FAULT : VERD_GO;
        OP_STORE, OP_DC_ZERO:                 v = (zd || wd) ? VERD_FAULT : VERD_GO;
        OP_DC_ALLOC:                          v = (zd || wd) ? VERD_NOP : VERD_GO;
        OP_DC_FLUSH, OP_DC_STBACK, OP_IC_INVAL: v = zd ? VERD_FAULT : VERD_GO;
        OP_DC_INVAL, OP_DC_CCINV:             v = wd ? VERD_FAULT : VERD_GO;
        OP_DC_TOUCH, OP_DC_TOUCHW:            v = zd ? VERD_NOP : VERD_GO;
        default:                              v = VERD_GO;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/zg_zone_file.sv
module zg_zone_file #(
  parameter int NUM_ZONES = 16,
  parameter int ZONE_W    = 2,
  localparam int REG_W    = NUM_ZONES * ZONE_W,
  localparam int IDX_W    = $clog2(NUM_ZONES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic [IDX_W-1:0]  sel,
  output logic [ZONE_W-1:0] zone
);

  logic [REG_W-1:0]  word_q;
  logic [ZONE_W-1:0] fields [NUM_ZONES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (we) word_q <= wdata;
  end

  // Zone 0 sits in the most significant field.
  for (genvar n = 0; n < NUM_ZONES; n++) begin : g_field
    assign fields[n] = word_q[REG_W-1-ZONE_W*n -: ZONE_W];
  end

  assign zone = fields[sel];

endmodule

// File: rtl/zg_rule_eval.sv
module zg_rule_eval
  import zg_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [ZONE_W-1:0] zone,
  input  logic              sup,
  input  logic              wr,
  input  logic              xlat,
  output verdict_e          verdict
);

  assign verdict = judge(op_e'(op), zone, sup, wr, xlat);

endmodule

// File: rtl/zg_verdict_reg.sv
module zg_verdict_reg
  import zg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  verdict_e in_verdict,
  output logic     out_valid,
  output verdict_e out_verdict
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_verdict <= VERD_GO;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_verdict <= in_verdict;
    end
  end

endmodule

// File: rtl/zone_guard.sv
module zone_guard
  import zg_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  localparam int REG_W    = NUM_ZONES * ZONE_W,
  localparam int IDX_W    = $clog2(NUM_ZONES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zpr_we,
  input  logic [REG_W-1:0]  zpr_wdata,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_zone,
  input  logic              req_wr,
  input  logic [OP_W-1:0]   req_op,
  input  logic              req_sup,
  input  logic              req_xlat,
  output logic              rsp_valid,
  output logic [1:0]        rsp_verdict
);

  // Named internal events, visible to the bound checker.
  logic [ZONE_W-1:0] zone_val;
  verdict_e          verdict_next;
  verdict_e          verdict_q;

  zg_zone_file #(.NUM_ZONES(NUM_ZONES), .ZONE_W(ZONE_W)) u_zones (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (zpr_we),
    .wdata (zpr_wdata),
    .sel   (req_zone),
    .zone  (zone_val)
  );

  zg_rule_eval u_rule (
    .op      (req_op),
    .zone    (zone_val),
    .sup     (req_sup),
    .wr      (req_wr),
    .xlat    (req_xlat),
    .verdict (verdict_next)
  );

  zg_verdict_reg u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (req_valid),
    .in_verdict  (verdict_next),
    .out_valid   (rsp_valid),
    .out_verdict (verdict_q)
  );

  assign rsp_verdict = verdict_q;

endmodule

// File: rtl/zone_guard_chk.sv
module zone_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] req_op,
  input logic       req_sup,
  input logic       req_xlat,
  input logic [1:0] zone_val,
  input logic       rsp_valid,
  input logic [1:0] rsp_verdict
);

  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r3_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_verdict != 2'b11));

  a_r4_xlat_off_go: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_xlat) |=> (rsp_verdict == 2'b00));

  a_r5_sup_load_go: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sup && req_op == 4'd0) |=> (rsp_verdict == 2'b00));

  a_r5_user_zone0_load_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_xlat && !req_sup && zone_val == 2'b00 && req_op == 4'd0)
      |=> (rsp_verdict == 2'b01));

  a_r10_alloc_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 4'd2) |=> (rsp_verdict != 2'b01));

  a_r11_touch_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 4'd6 || req_op == 4'd7)) |=> (rsp_verdict != 2'b01));

  a_r12_passive_ops_go: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 4'd10 || req_op >= 4'd12)) |=> (rsp_verdict == 2'b00));

endmodule

bind zone_guard zone_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_sup     (req_sup),
  .req_xlat    (req_xlat),
  .zone_val    (zone_val),
  .rsp_valid   (rsp_valid),
  .rsp_verdict (rsp_verdict)
);

// File: tb/tb_zone_guard.sv
module tb_zone_guard;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        zpr_we = 1'b0;
  logic [31:0] zpr_wdata = '0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_zone = '0;
  logic        req_wr = 1'b0;
  logic [3:0]  req_op = '0;
  logic        req_sup = 1'b0;
  logic        req_xlat = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_verdict;

  int checks = 0;
  int errors = 0;
  logic [31:0] zword = '0;  // bench copy of the zone word

  zone_guard dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Rule kinds: which condition faults and which turns into a no-op.
  function automatic logic [1:0] model(input int op, input int z, input bit sup,
                                       input bit wr, input bit xlat);
    bit zhit, whit;
    bit f_z, f_w, n_z, n_w;
    zhit = (z == 0) && !sup;
    whit = !(wr || z == 3 || (z == 2 && sup));
    {f_z, f_w, n_z, n_w} = 4'b0000;
    if (op == 0 || op == 3 || op == 5 || op == 11) f_z = 1;
    if (op == 4 || op == 9) f_w = 1;
    if (op == 1 || op == 8) begin f_z = 1; f_w = 1; end
    if (op == 2) begin n_z = 1; n_w = 1; end
    if (op == 6 || op == 7) n_z = 1;
    if (!xlat) return 2'b00;
    if ((f_z && zhit) || (f_w && whit)) return 2'b01;
    if ((n_z && zhit) || (n_w && whit)) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R5";
      1: return "R6";
      2: return "R10";
      3, 5, 11: return "R7";
      4, 9: return "R8";
      8: return "R9";
      6, 7: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic int zone_of(input logic [31:0] w, input int n);
    logic [31:0] s;
    s = w >> (30 - 2 * n);
    return int'(s[1:0]);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    zpr_we = 1'b1; zpr_wdata = w;
    @(negedge clk);
    zpr_we = 1'b0;
    zword = w;
  endtask

  // Request at a falling edge, verdict sampled one falling edge later.
  task automatic request(input int op, input int zi, input bit wr, input bit sup,
                         input bit xlat, input string tag);
    logic [1:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'(op); req_zone = 4'(zi);
    req_wr = wr; req_sup = sup; req_xlat = xlat;
    exp = model(op, zone_of(zword, zi), sup, wr, xlat);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3", "rsp_valid", 32'(rsp_valid), 32'd1);
    check(tag, $sformatf("op%0d zone%0d wr%0d sup%0d xlat%0d", op, zi, wr, sup, xlat),
          32'(rsp_verdict), 32'(exp));
  endtask

  task automatic t_reset;
    check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1", "verdict after reset", 32'(rsp_verdict), 32'd0);
    // all zones 00: user load in zone 7 faults
    request(0, 7, 1'b1, 1'b0, 1'b1, "R1");
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R3", "rsp_valid idle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_field_positions;
    write_word(32'h0000_0003);           // zone 15 = 11, others 00
    request(1, 15, 1'b0, 1'b0, 1'b1, "R2");
    request(1, 14, 1'b1, 1'b0, 1'b1, "R2");
    write_word(32'hC000_0000);           // zone 0 = 11
    request(1, 0, 1'b0, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_same_cycle_write;
    write_word(32'h0000_0000);
    @(negedge clk);
    zpr_we = 1'b1; zpr_wdata = 32'hC000_0000;
    req_valid = 1'b1; req_op = 4'd0; req_zone = 4'd0;
    req_wr = 1'b1; req_sup = 1'b0; req_xlat = 1'b1;
    @(negedge clk);
    zpr_we = 1'b0; req_valid = 1'b0;
    zword = 32'hC000_0000;
    check("R2", "same-cycle write uses old word", 32'(rsp_verdict), 32'd1);
    request(0, 0, 1'b1, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_xlat_off;
    write_word(32'h0000_0000);
    for (int op = 0; op < 16; op++) request(op, 3, 1'b0, 1'b0, 1'b0, "R4");
  endtask

  // Zones 0..3 hold 00, 01, 10, 11; sweep every op and condition.
  task automatic t_sweep;
    write_word(32'h1B00_0000);
    for (int op = 0; op < 16; op++)
      for (int zi = 0; zi < 4; zi++)
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < 2; w++)
            request(op, zi, w[0], s[0], 1'b1, tag_of(op));
  endtask

  task automatic t_reset_mid;
    write_word(32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    zword = '0;
    check("R1", "rsp_valid after second reset", 32'(rsp_valid), 32'd0);
    request(8, 5, 1'b1, 1'b0, 1'b1, "R1");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_field_positions();
    t_same_cycle_write();
    t_xlat_off();
    t_sweep();
    t_idle();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule